// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block sits at the front of a pipelined burst memory. It registers a word address when a burst opens and then supplies the low address bits for each beat of a four-beat burst. The upper address stays fixed for the whole burst. The low offset moves only when the advance input asks for it.

A burst opens on either of two active-low strobes. The processor strobe counts only while the primary chip select is asserted. The controller strobe is always taken: it loads the address and sets the access-valid flag from the chip select. A static mode input picks the beat order. In linear order the offset counts up modulo four. In interleaved order the offset is the starting offset XORed with the beat number. After the fourth beat the offset returns to the starting value and never carries into the upper address.

Top module: `burst_addr_seq`

## Requirements
- R1: A low `srst_n` at a clock edge clears `acc_valid`, `upper_addr` and `beat_off` to zero after that edge, even while a strobe is asserted.
- R2: When `proc_stb_n` and `sel_n` are both low at an edge, `upper_addr` takes `addr_in[ADDR_W-1:BURST_W]`, `beat_off` takes `addr_in[BURST_W-1:0]` and `acc_valid` becomes 1.
- R3: When `proc_stb_n` is low, `sel_n` is high and `ctrl_stb_n` is high, the processor strobe is ignored. `upper_addr` and `acc_valid` keep their values, and an advance in the same cycle still steps the running burst.
- R4: When `ctrl_stb_n` is low and the processor strobe is not accepted, the address loads as in R2 and `acc_valid` becomes 1 if `sel_n` is low, or 0 if it is high.
- R5: With both strobes low in one cycle, the processor strobe wins when `sel_n` is low (load, valid 1). When `sel_n` is high, the controller strobe still loads with valid 0.
- R6: With both strobes high and `adv_n` high, `beat_off` holds its value.
- R7: With `order_il` = 0 (linear), each advance adds one to `beat_off` modulo 4. Example: start 1 gives 1,2,3,0.
- R8: With `order_il` = 1 (interleaved), the n-th advance gives start XOR n. Example: start 3 gives 3,2,1,0.
- R9: After four advances `beat_off` is back at the starting offset and `upper_addr` is unchanged.
- R10: While `acc_valid` is 0, `adv_n` low with no strobe leaves `beat_off` unchanged.
- R11: An accepted strobe in the middle of a burst restarts the beat count at the new starting offset. It takes precedence over an advance in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every register captures on the rising edge |
| srst_n | input | 1 | Synchronous reset, active low |
| addr_in | input | ADDR_W | External word address |
| proc_stb_n | input | 1 | Processor burst-start strobe, active low, gated by `sel_n` |
| ctrl_stb_n | input | 1 | Controller burst-start strobe, active low |
| sel_n | input | 1 | Primary chip select, active low |
| adv_n | input | 1 | Burst advance, active low |
| order_il | input | 1 | Static order select: 0 linear, 1 interleaved |
| upper_addr | output | ADDR_W-BURST_W | Registered upper address of the burst |
| beat_off | output | BURST_W | Current registered burst offset |
| acc_valid | output | 1 | Access-valid flag |

## Verification
The bench builds the block with ADDR_W = 8 and BURST_W = 2. The 6-bit upper field is small enough that every loaded address can be checked exactly. The two offset bits make each four-beat wrap reachable within a handful of cycles. Both beat orders are tried from starting offsets where linear and interleaved sequences differ. The strobe, chip-select and advance inputs are combined in the same cycle to expose priority and gating.

// File: rtl/bsq_pkg.sv
package bsq_pkg;

   typedef enum logic [1:0] {
      START_NONE = 2'd0,
      START_PROC = 2'd1,
      START_CTRL = 2'd2
   } start_kind_e;

endpackage

// File: rtl/bsq_start_arb.sv
// Decides which strobe, if any, opens a burst this cycle.
module bsq_start_arb
   import bsq_pkg::*;
(
   input  logic        proc_stb_n,
   input  logic        ctrl_stb_n,
   input  logic        sel_n,
   output start_kind_e kind,
   output logic        valid_d
);

   logic proc_ok;

   // the processor strobe counts only under an active primary select
   assign proc_ok = !proc_stb_n && !sel_n;

   always_comb begin
      kind    = START_NONE;
      valid_d = 1'b0;
      if (proc_ok) begin
         kind    = START_PROC;
         valid_d = 1'b1;
      end else if (!ctrl_stb_n) begin
         kind    = START_CTRL;
         valid_d = !sel_n;
      end
   end

endmodule

// File: rtl/bsq_order.sv
// Maps a starting offset and a beat number to the offset of that beat.
module bsq_order #(
   parameter int W = 2
) (
   input  logic [W-1:0] start,
   input  logic [W-1:0] beat,
   input  logic         il,
   output logic [W-1:0] off
);

   logic [W-1:0] lin_off;
   logic [W-1:0] il_off;

   assign lin_off = start + beat;

   for (genvar b = 0; b < W; b++) begin : g_il_bit
      assign il_off[b] = start[b] ^ beat[b];
   end

   assign off = il ? il_off : lin_off;

endmodule

// File: rtl/bsq_beat_ctr.sv
// Holds the starting offset and beat count; registers the offset output.
module bsq_beat_ctr #(
   parameter int W = 2
) (
   input  logic         clk,
   input  logic         srst_n,
   input  logic         load,
   input  logic         step,
   input  logic         il,
   input  logic [W-1:0] start_in,
   output logic [W-1:0] off_q
);

   logic [W-1:0] start_q;
   logic [W-1:0] cnt_q;
   logic [W-1:0] start_d;
   logic [W-1:0] cnt_d;
   logic [W-1:0] off_d;

   assign start_d = load ? start_in : start_q;
   assign cnt_d   = load ? '0 : cnt_q + 1'b1;

   bsq_order #(.W(W)) u_order (
      .start (start_d),
      .beat  (cnt_d),
      .il    (il),
      .off   (off_d)
   );

   always_ff @(posedge clk) begin
      if (!srst_n) begin
         start_q <= '0;
         cnt_q   <= '0;
         off_q   <= '0;
      end else if (load || step) begin
         start_q <= start_d;
         cnt_q   <= cnt_d;
         off_q   <= off_d;
      end
   end

endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
   import bsq_pkg::*;
#(
   parameter int ADDR_W  = 17,
   parameter int BURST_W = 2
) (
   input  logic                      clk,
   input  logic                      srst_n,
   input  logic [ADDR_W-1:0]         addr_in,
   input  logic                      proc_stb_n,
   input  logic                      ctrl_stb_n,
   input  logic                      sel_n,
   input  logic                      adv_n,
   input  logic                      order_il,
   output logic [ADDR_W-BURST_W-1:0] upper_addr,
   output logic [BURST_W-1:0]        beat_off,
   output logic                      acc_valid
);

   localparam int UPPER_W = ADDR_W - BURST_W;

   if (BURST_W < 1) begin : g_bad_burst
      $error("burst_addr_seq: BURST_W must be at least 1");
   end
   if (UPPER_W < 1) begin : g_bad_addr
      $error("burst_addr_seq: ADDR_W must exceed BURST_W");
   end

   start_kind_e      kind;
   logic             valid_d;
   logic             load;
   logic             step;
   logic             valid_q;
   logic [UPPER_W-1:0] upper_q;

   bsq_start_arb u_arb (
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .sel_n      (sel_n),
      .kind       (kind),
      .valid_d    (valid_d)
   );

   assign load = (kind != START_NONE);
   assign step = !adv_n && valid_q && !load;

   always_ff @(posedge clk) begin
      if (!srst_n) begin
         valid_q <= 1'b0;
         upper_q <= '0;
      end else if (load) begin
         valid_q <= valid_d;
         upper_q <= addr_in[ADDR_W-1:BURST_W];
      end
   end

   bsq_beat_ctr #(.W(BURST_W)) u_ctr (
      .clk      (clk),
      .srst_n   (srst_n),
      .load     (load),
      .step     (step),
      .il       (order_il),
      .start_in (addr_in[BURST_W-1:0]),
      .off_q    (beat_off)
   );

   assign upper_addr = upper_q;
   assign acc_valid  = valid_q;

endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
   parameter int ADDR_W  = 17,
   parameter int BURST_W = 2
) (
   input logic                      clk,
   input logic                      srst_n,
   input logic [ADDR_W-1:0]         addr_in,
   input logic                      proc_stb_n,
   input logic                      ctrl_stb_n,
   input logic                      sel_n,
   input logic                      adv_n,
   input logic                      order_il,
   input logic [ADDR_W-BURST_W-1:0] upper_addr,
   input logic [BURST_W-1:0]        beat_off,
   input logic                      acc_valid
);

   logic rst_prev = 1'b0;

   always @(posedge clk) rst_prev <= !srst_n;

   // R1: the edge after a reset edge shows cleared outputs
   always @(posedge clk) begin
      if (rst_prev) begin
         a_r1_reset_clears: assert (!acc_valid && beat_off == '0 && upper_addr == '0)
            else $error("reset did not clear outputs");
      end
   end

   a_r2_proc_load: assert property (@(posedge clk) disable iff (!srst_n)
      (!proc_stb_n && !sel_n) |=> (acc_valid
         && upper_addr == $past(addr_in[ADDR_W-1:BURST_W])
         && beat_off == $past(addr_in[BURST_W-1:0])));

   a_r3_proc_blocked: assert property (@(posedge clk) disable iff (!srst_n)
      (!proc_stb_n && sel_n && ctrl_stb_n) |=> ($stable(upper_addr) && $stable(acc_valid)));

   a_r4_ctrl_deselect: assert property (@(posedge clk) disable iff (!srst_n)
      (!ctrl_stb_n && sel_n) |=> !acc_valid);

   a_r6_hold: assert property (@(posedge clk) disable iff (!srst_n)
      (proc_stb_n && ctrl_stb_n && adv_n) |=> $stable(beat_off));

   a_r7_linear_step: assert property (@(posedge clk) disable iff (!srst_n)
      (proc_stb_n && ctrl_stb_n && !adv_n && acc_valid && !order_il)
         |=> beat_off == $past(beat_off) + 1'b1);

   a_r10_idle_advance: assert property (@(posedge clk) disable iff (!srst_n)
      (proc_stb_n && ctrl_stb_n && !acc_valid) |=> $stable(beat_off));

endmodule

bind burst_addr_seq burst_addr_seq_chk #(.ADDR_W(ADDR_W), .BURST_W(BURST_W)) u_chk (.*);

// File: tb/burst_addr_seq_bench.sv
`timescale 1ns/1ps
module burst_addr_seq_bench;

   localparam int AW = 8;
   localparam int BW = 2;
   localparam int UW = AW - BW;

   logic          clk = 1'b0;
   logic          srst_n;
   logic [AW-1:0] addr_in;
   logic          proc_stb_n, ctrl_stb_n, sel_n, adv_n, order_il;
   logic [UW-1:0] upper_addr;
   logic [BW-1:0] beat_off;
   logic          acc_valid;

   int n_checks = 0;
   int n_fails  = 0;

   always #2 clk = ~clk;

   burst_addr_seq #(.ADDR_W(AW), .BURST_W(BW)) u_burst_addr_seq (
      .clk        (clk),
      .srst_n     (srst_n),
      .addr_in    (addr_in),
      .proc_stb_n (proc_stb_n),
      .ctrl_stb_n (ctrl_stb_n),
      .sel_n      (sel_n),
      .adv_n      (adv_n),
      .order_il   (order_il),
      .upper_addr (upper_addr),
      .beat_off   (beat_off),
      .acc_valid  (acc_valid)
   );

   typedef struct packed {
      logic          p;
      logic          c;
      logic          s;
      logic          a;
      logic          m;
      logic [7:0]    addr;
      logic          ev;
      logic [5:0]    eu;
      logic [1:0]    eo;
      logic [7:0]    req;
   } vec_t;

   localparam int NV = 23;
   //                  p     c     s     a     m     addr   ev    eu     eo    req
   localparam vec_t VEC [NV] = '{
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 8'h35, 1'b1, 6'h0D, 2'd1, 8'd2},  // R2
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd2, 8'd7},  // R7
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd3, 8'd7},  // R7
      '{1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd3, 8'd6},  // R6
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd0, 8'd7},  // R7
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd1, 8'd9},  // R9
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b1, 6'h0D, 2'd2, 8'd7},  // R7
      '{1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h87, 1'b1, 6'h21, 2'd3, 8'd4},  // R4
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h21, 2'd2, 8'd8},  // R8
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h21, 2'd1, 8'd8},  // R8
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h21, 2'd0, 8'd8},  // R8
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h21, 2'd3, 8'd9},  // R9
      '{1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hFF, 1'b1, 6'h21, 2'd3, 8'd3},  // R3
      '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 8'hFF, 1'b1, 6'h21, 2'd2, 8'd3},  // R3
      '{1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 8'h12, 1'b1, 6'h04, 2'd2, 8'd5},  // R5
      '{1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'h2D, 1'b0, 6'h0B, 2'd1, 8'd5},  // R5
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'h00, 1'b0, 6'h0B, 2'd1, 8'd10}, // R10
      '{1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 8'h00, 1'b0, 6'h00, 2'd0, 8'd4},  // R4
      '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 8'h3E, 1'b1, 6'h0F, 2'd2, 8'd2},  // R2
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h0F, 2'd3, 8'd8},  // R8
      '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 8'h41, 1'b1, 6'h10, 2'd1, 8'd11}, // R11
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h10, 2'd0, 8'd11}, // R11
      '{1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 8'h00, 1'b1, 6'h10, 2'd3, 8'd8}   // R8
   };

   task automatic chk(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic idle();
      proc_stb_n = 1'b1;
      ctrl_stb_n = 1'b1;
      sel_n      = 1'b0;
      adv_n      = 1'b1;
      addr_in    = '0;
   endtask

   task automatic finish_run();
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   endtask

   initial begin
      srst_n   = 1'b0;
      order_il = 1'b0;
      idle();
      repeat (2) @(posedge clk);
      #1;
      chk("R1 valid after reset", int'(acc_valid), 0);
      chk("R1 offset after reset", int'(beat_off), 0);
      chk("R1 upper after reset", int'(upper_addr), 0);
      srst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         proc_stb_n = VEC[i].p;
         ctrl_stb_n = VEC[i].c;
         sel_n      = VEC[i].s;
         adv_n      = VEC[i].a;
         order_il   = VEC[i].m;
         addr_in    = VEC[i].addr;
         @(posedge clk);
         #1;
         chk($sformatf("R%0d row %0d valid", VEC[i].req, i), int'(acc_valid), int'(VEC[i].ev));
         chk($sformatf("R%0d row %0d upper", VEC[i].req, i), int'(upper_addr), int'(VEC[i].eu));
         chk($sformatf("R%0d row %0d offset", VEC[i].req, i), int'(beat_off), int'(VEC[i].eo));
      end

      // R1: reset wins over an accepted strobe mid-burst
      proc_stb_n = 1'b0;
      sel_n      = 1'b0;
      addr_in    = 8'hAA;
      srst_n     = 1'b0;
      @(posedge clk);
      #1;
      chk("R1 valid under strobe", int'(acc_valid), 0);
      chk("R1 upper under strobe", int'(upper_addr), 0);
      chk("R1 offset under strobe", int'(beat_off), 0);

      // R10: advance with no open burst after reset
      srst_n = 1'b1;
      idle();
      adv_n = 1'b0;
      repeat (2) @(posedge clk);
      #1;
      chk("R10 offset idle advance", int'(beat_off), 0);
      chk("R10 valid idle advance", int'(acc_valid), 0);

      idle();
      @(posedge clk);
      #1;
      finish_run();
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

endmodule